// File: doc/BRIEF.md
# Pending Task Join Store

This block keeps tasks that cannot yet run because some of their input values are still missing. A producer asks for a new pending entry by giving a task type and the number of values the task is waiting for. The store takes an unused entry, records the type and the missing count, and answers with the entry index. That index, together with an argument position, forms the continuation that later value messages carry.

Each arriving value names its continuation, its data and the processing element that produced it. The store writes the data into the named argument position and counts the entry down by one. When the count runs out, the store assembles the full task, made of the type and every argument value, and sends it out addressed to the processing element that delivered the final value. In the same step it returns the entry to the pool of unused entries. One operation is served per cycle, and a value message always goes ahead of a create request.

Top module: `join_store`

## Requirements
- R1: After reset every entry is free: `cr_ready` and `arg_ready` are 1, and `rsp_valid` and `task_valid` are 0.
- R2: A create request is accepted on a cycle where `cr_valid` and `cr_ready` are both 1. The cycle after that, `rsp_valid` is 1 and `rsp_entry` holds the lowest-numbered free entry. No entry is handed out twice while it is pending. `cr_nargs` must be between 1 and NSLOTS.
- R3: While no entry is free, `cr_ready` is 0 and no create response is produced.
- R4: An accepted value message whose entry still needs more values after it produces no task.
- R5: The value that brings an entry's count to zero makes `task_valid` 1 on the following cycle. That task carries the stored type in `task_type`, and argument position s in `task_args[s*DATA_W +: DATA_W]`. `task_dest` equals the `arg_src` of that final value. Values may arrive in any order of positions.
- R6: Once a task has been emitted, its entry is free again and a later create can receive it under the lowest-free rule.
- R7: When `arg_valid` is 1, `cr_ready` is 0 in that cycle. The value is served first and the create request waits.
- R8: While `task_valid` is 1 and `task_ready` is 0, the task outputs hold steady and `arg_ready` is 0.
- R9: An accepted value message is ignored in two cases: when it names an entry that is not pending, or when it names a position of NSLOTS or more. It emits no task. The continuation is `arg_cont = {entry, position}`, with the position in the low $clog2(NSLOTS) bits.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_entry` holds steady and `cr_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr_valid | input | 1 | Create request present |
| cr_ready | output | 1 | Create request can be taken |
| cr_type | input | TYPE_W | Task type to store |
| cr_nargs | input | $clog2(NSLOTS+1) | Number of values the task waits for |
| rsp_valid | output | 1 | Create response present |
| rsp_ready | input | 1 | Create response consumed |
| rsp_entry | output | $clog2(ENTRIES) | Allocated entry index |
| arg_valid | input | 1 | Value message present |
| arg_ready | output | 1 | Value message can be taken |
| arg_cont | input | $clog2(ENTRIES)+$clog2(NSLOTS) | Continuation {entry, position} |
| arg_data | input | DATA_W | Value |
| arg_src | input | PE_W | Producing processing element |
| task_valid | output | 1 | Ready task present |
| task_ready | input | 1 | Ready task consumed |
| task_type | output | TYPE_W | Type of ready task |
| task_args | output | NSLOTS*DATA_W | All argument values |
| task_dest | output | PE_W | Destination processing element |

## Verification
Both results of the block come one register after the accepting edge. The create response and the emitted task each appear the cycle after the create or the final value was taken. The stall signals `cr_ready` and `arg_ready` respond in the same cycle, because they are combinational. The bench drives inputs on falling edges and waits there until the ready signal is 1. It samples responses at the falling edge just after the accepting rising edge, and checks the same-cycle ready signals at the falling edge where the stimulus is applied. The sweep covers every argument count up to three and every rotation of value arrival order.

// File: rtl/js_pkg.sv
package js_pkg;
   typedef enum logic [1:0] {
      JS_IDLE   = 2'd0,
      JS_ARG    = 2'd1,
      JS_CREATE = 2'd2
   } js_op_e;
endpackage

// File: rtl/js_free_list.sv
module js_free_list #(
   parameter int ENTRIES = 4,
   localparam int EIDX_W = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_i,
   input  logic              rel_i,
   input  logic [EIDX_W-1:0] rel_idx_i,
   output logic              any_free_o,
   output logic [EIDX_W-1:0] free_idx_o,
   output logic [ENTRIES-1:0] free_map_o
);
   logic [ENTRIES-1:0] free_q;

   // lowest set bit wins
   always_comb begin
      free_idx_o = '0;
      for (int i = ENTRIES - 1; i >= 0; i--)
         if (free_q[i]) free_idx_o = EIDX_W'(i);
   end

   assign any_free_o = |free_q;
   assign free_map_o = free_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_q <= '1;
      end else begin
         if (alloc_i) free_q[free_idx_o] <= 1'b0;
         if (rel_i)   free_q[rel_idx_i]  <= 1'b1;
      end
   end
endmodule

// File: rtl/js_join_ctr.sv
module js_join_ctr #(
   parameter int ENTRIES = 4,
   parameter int NSLOTS  = 3,
   localparam int EIDX_W = $clog2(ENTRIES),
   localparam int CNT_W  = $clog2(NSLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [EIDX_W-1:0] load_idx_i,
   input  logic [CNT_W-1:0]  load_cnt_i,
   input  logic              dec_i,
   input  logic [EIDX_W-1:0] dec_idx_i,
   output logic              pending_o,
   output logic              last_o,
   output logic [ENTRIES-1:0] pend_map_o
);
   logic [ENTRIES*CNT_W-1:0] cnt_flat;
   logic [CNT_W-1:0]         sel_cnt;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (load_i && load_idx_i == EIDX_W'(e))
            cnt_q <= load_cnt_i;
         else if (dec_i && dec_idx_i == EIDX_W'(e) && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end
      assign cnt_flat[e*CNT_W +: CNT_W] = cnt_q;
      assign pend_map_o[e]              = (cnt_q != '0);
   end

   assign sel_cnt   = cnt_flat[dec_idx_i*CNT_W +: CNT_W];
   assign pending_o = (sel_cnt != '0);
   assign last_o    = (sel_cnt == CNT_W'(1));
endmodule

// File: rtl/js_arg_array.sv
module js_arg_array #(
   parameter int ENTRIES = 4,
   parameter int NSLOTS  = 3,
   parameter int DATA_W  = 8,
   localparam int EIDX_W = $clog2(ENTRIES),
   localparam int SIDX_W = $clog2(NSLOTS)
) (
   input  logic                     clk,
   input  logic                     we_i,
   input  logic [EIDX_W-1:0]        widx_i,
   input  logic [SIDX_W-1:0]        wslot_i,
   input  logic [DATA_W-1:0]        wdata_i,
   input  logic [EIDX_W-1:0]        ridx_i,
   output logic [NSLOTS*DATA_W-1:0] row_o
);
   logic [NSLOTS*DATA_W-1:0] mem [ENTRIES];

   always_ff @(posedge clk) begin
      if (we_i)
         for (int s = 0; s < NSLOTS; s++)
            if (wslot_i == SIDX_W'(s))
               mem[widx_i][s*DATA_W +: DATA_W] <= wdata_i;
   end

   assign row_o = mem[ridx_i];
endmodule

// File: rtl/join_store.sv
module join_store #(
   parameter int ENTRIES = 4,
   parameter int NSLOTS  = 3,
   parameter int DATA_W  = 8,
   parameter int TYPE_W  = 3,
   parameter int PE_W    = 2,
   localparam int EIDX_W = $clog2(ENTRIES),
   localparam int SIDX_W = $clog2(NSLOTS),
   localparam int CNT_W  = $clog2(NSLOTS + 1),
   localparam int CONT_W = EIDX_W + SIDX_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cr_valid,
   output logic                     cr_ready,
   input  logic [TYPE_W-1:0]        cr_type,
   input  logic [CNT_W-1:0]         cr_nargs,
   output logic                     rsp_valid,
   input  logic                     rsp_ready,
   output logic [EIDX_W-1:0]        rsp_entry,
   input  logic                     arg_valid,
   output logic                     arg_ready,
   input  logic [CONT_W-1:0]        arg_cont,
   input  logic [DATA_W-1:0]        arg_data,
   input  logic [PE_W-1:0]          arg_src,
   output logic                     task_valid,
   input  logic                     task_ready,
   output logic [TYPE_W-1:0]        task_type,
   output logic [NSLOTS*DATA_W-1:0] task_args,
   output logic [PE_W-1:0]          task_dest
);
   import js_pkg::*;

   initial begin
      assert (ENTRIES >= 2) else $error("join_store: ENTRIES must be at least 2");
      assert (NSLOTS >= 2)  else $error("join_store: NSLOTS must be at least 2");
      assert (DATA_W >= 1 && TYPE_W >= 1 && PE_W >= 1)
         else $error("join_store: widths must be positive");
   end

   logic [EIDX_W-1:0]        a_idx;
   logic [SIDX_W-1:0]        a_slot;
   logic                     slot_ok, pending, last, any_free;
   logic [EIDX_W-1:0]        free_idx;
   logic [ENTRIES-1:0]       free_map, pend_map;
   logic                     rsp_room, task_room;
   logic                     arg_hit, complete;
   logic [NSLOTS*DATA_W-1:0] row, merged;
   logic [TYPE_W-1:0]        type_q [ENTRIES];
   js_op_e                   op;

   assign a_idx  = arg_cont[CONT_W-1:SIDX_W];
   assign a_slot = arg_cont[SIDX_W-1:0];
   assign slot_ok = int'(a_slot) < NSLOTS;

   assign rsp_room  = !rsp_valid || rsp_ready;
   assign task_room = !task_valid || task_ready;
   assign arg_ready = task_room;
   assign cr_ready  = any_free && !arg_valid && rsp_room;

   always_comb begin
      op = JS_IDLE;
      if (arg_valid && arg_ready)     op = JS_ARG;
      else if (cr_valid && cr_ready)  op = JS_CREATE;
   end

   assign arg_hit  = (op == JS_ARG) && pending && slot_ok;
   assign complete = arg_hit && last;

   js_free_list #(.ENTRIES(ENTRIES)) u_free (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_i    (op == JS_CREATE),
      .rel_i      (complete),
      .rel_idx_i  (a_idx),
      .any_free_o (any_free),
      .free_idx_o (free_idx),
      .free_map_o (free_map)
   );

   js_join_ctr #(.ENTRIES(ENTRIES), .NSLOTS(NSLOTS)) u_join (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (op == JS_CREATE),
      .load_idx_i (free_idx),
      .load_cnt_i (cr_nargs),
      .dec_i      (arg_hit),
      .dec_idx_i  (a_idx),
      .pending_o  (pending),
      .last_o     (last),
      .pend_map_o (pend_map)
   );

   js_arg_array #(.ENTRIES(ENTRIES), .NSLOTS(NSLOTS), .DATA_W(DATA_W)) u_args (
      .clk     (clk),
      .we_i    (arg_hit),
      .widx_i  (a_idx),
      .wslot_i (a_slot),
      .wdata_i (arg_data),
      .ridx_i  (a_idx),
      .row_o   (row)
   );

   // final value bypasses the array straight into the task
   always_comb begin
      merged = row;
      for (int s = 0; s < NSLOTS; s++)
         if (a_slot == SIDX_W'(s)) merged[s*DATA_W +: DATA_W] = arg_data;
   end

   always_ff @(posedge clk) begin
      if (op == JS_CREATE) type_q[free_idx] <= cr_type;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_entry <= '0;
      end else if (op == JS_CREATE) begin
         rsp_valid <= 1'b1;
         rsp_entry <= free_idx;
      end else if (rsp_ready) begin
         rsp_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         task_valid <= 1'b0;
         task_type  <= '0;
         task_args  <= '0;
         task_dest  <= '0;
      end else if (complete) begin
         task_valid <= 1'b1;
         task_type  <= type_q[a_idx];
         task_args  <= merged;
         task_dest  <= arg_src;
      end else if (task_ready) begin
         task_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/js_chk.sv
module js_chk #(
   parameter int ENTRIES = 4,
   parameter int NSLOTS  = 3,
   parameter int DATA_W  = 8,
   parameter int TYPE_W  = 3,
   parameter int PE_W    = 2,
   localparam int EIDX_W = $clog2(ENTRIES),
   localparam int CNT_W  = $clog2(NSLOTS + 1)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cr_valid,
   input logic                     cr_ready,
   input logic [CNT_W-1:0]         cr_nargs,
   input logic                     rsp_valid,
   input logic                     rsp_ready,
   input logic [EIDX_W-1:0]        rsp_entry,
   input logic                     arg_valid,
   input logic                     arg_ready,
   input logic                     task_valid,
   input logic                     task_ready,
   input logic [TYPE_W-1:0]        task_type,
   input logic [NSLOTS*DATA_W-1:0] task_args,
   input logic [PE_W-1:0]          task_dest,
   input logic [ENTRIES-1:0]       free_map,
   input logic [ENTRIES-1:0]       pend_map
);
   a_r2_no_double_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      (free_map & pend_map) == '0);

   a_r2_nargs_legal: assert property (@(posedge clk) disable iff (!rst_n)
      cr_valid |-> (cr_nargs != '0 && cr_nargs <= CNT_W'(NSLOTS)));

   a_r3_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (free_map == '0) |-> !cr_ready);

   a_r7_arg_first: assert property (@(posedge clk) disable iff (!rst_n)
      arg_valid |-> !cr_ready);

   a_r8_task_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (task_valid && !task_ready) |=> (task_valid && $stable(task_args)
                                      && $stable(task_type) && $stable(task_dest)));

   a_r8_arg_block: assert property (@(posedge clk) disable iff (!rst_n)
      (task_valid && !task_ready) |-> !arg_ready);

   a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_entry)));

   a_r10_rsp_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |-> !cr_ready);
endmodule

bind join_store js_chk #(
   .ENTRIES(ENTRIES), .NSLOTS(NSLOTS), .DATA_W(DATA_W),
   .TYPE_W(TYPE_W), .PE_W(PE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cr_valid(cr_valid), .cr_ready(cr_ready),
   .cr_nargs(cr_nargs), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
   .rsp_entry(rsp_entry), .arg_valid(arg_valid), .arg_ready(arg_ready),
   .task_valid(task_valid), .task_ready(task_ready), .task_type(task_type),
   .task_args(task_args), .task_dest(task_dest),
   .free_map(free_map), .pend_map(pend_map)
);

// File: tb/join_store_bench.sv
`timescale 1ns/1ps
module join_store_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cr_valid = 1'b0, cr_ready;
   logic [2:0]  cr_type = '0;
   logic [1:0]  cr_nargs = 2'd1;
   logic        rsp_valid, rsp_ready = 1'b1;
   logic [1:0]  rsp_entry;
   logic        arg_valid = 1'b0, arg_ready;
   logic [3:0]  arg_cont = '0;
   logic [7:0]  arg_data = '0;
   logic [1:0]  arg_src = '0;
   logic        task_valid, task_ready = 1'b1;
   logic [2:0]  task_type;
   logic [23:0] task_args;
   logic [1:0]  task_dest;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   join_store u_join_store (
      .clk(clk), .rst_n(rst_n),
      .cr_valid(cr_valid), .cr_ready(cr_ready), .cr_type(cr_type), .cr_nargs(cr_nargs),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_entry(rsp_entry),
      .arg_valid(arg_valid), .arg_ready(arg_ready), .arg_cont(arg_cont),
      .arg_data(arg_data), .arg_src(arg_src),
      .task_valid(task_valid), .task_ready(task_ready), .task_type(task_type),
      .task_args(task_args), .task_dest(task_dest)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic create(input logic [2:0] ty, input logic [1:0] n, output logic [1:0] ent);
      @(negedge clk);
      cr_valid = 1'b1; cr_type = ty; cr_nargs = n;
      while (!cr_ready) @(negedge clk);
      @(negedge clk);
      cr_valid = 1'b0;
      chk(rsp_valid == 1'b1, "R2 response one cycle after accept", 32'(rsp_valid), 1);
      ent = rsp_entry;
   endtask

   task automatic send_arg(input logic [1:0] ent, input logic [1:0] slot,
                           input logic [7:0] d, input logic [1:0] src);
      @(negedge clk);
      arg_valid = 1'b1; arg_cont = {ent, slot}; arg_data = d; arg_src = src;
      while (!arg_ready) @(negedge clk);
      @(negedge clk);
      arg_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [1:0] e;
      logic [1:0] ents [4];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cr_ready == 1'b1, "R1 cr_ready after reset", 32'(cr_ready), 1);
      chk(arg_ready == 1'b1, "R1 arg_ready after reset", 32'(arg_ready), 1);
      chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 0);
      chk(task_valid == 1'b0, "R1 task_valid after reset", 32'(task_valid), 0);

      // R2/R3: fill the store, entries in ascending order
      for (int i = 0; i < 4; i++) begin
         create(3'(i), 2'((i % 3) + 1), ents[i]);
         chk(ents[i] == 2'(i), "R2 lowest free entry", 32'(ents[i]), 32'(i));
      end
      @(negedge clk);
      chk(cr_ready == 1'b0, "R3 cr_ready low when full", 32'(cr_ready), 0);
      cr_valid = 1'b1; cr_type = 3'd7; cr_nargs = 2'd1;
      repeat (3) begin
         @(negedge clk);
         chk(cr_ready == 1'b0, "R3 stall while full", 32'(cr_ready), 0);
         chk(rsp_valid == 1'b0, "R3 no response while full", 32'(rsp_valid), 0);
      end
      cr_valid = 1'b0;

      // R4/R5: entry 2 waits for 3 values, delivered out of order
      send_arg(2'd2, 2'd2, 8'hC2, 2'd1);
      chk(task_valid == 1'b0, "R4 no task after first of three", 32'(task_valid), 0);
      send_arg(2'd2, 2'd0, 8'hC0, 2'd2);
      chk(task_valid == 1'b0, "R4 no task after second of three", 32'(task_valid), 0);
      send_arg(2'd2, 2'd1, 8'hC1, 2'd3);
      chk(task_valid == 1'b1, "R5 task after final value", 32'(task_valid), 1);
      chk(task_type == 3'd2, "R5 task type", 32'(task_type), 2);
      chk(task_args == 24'hC2C1C0, "R5 assembled args", task_args, 32'hC2C1C0);
      chk(task_dest == 2'd3, "R5 dest is last producer", 32'(task_dest), 3);

      // R6: freed entry reused
      create(3'd4, 2'd1, e);
      chk(e == 2'd2, "R6 freed entry reallocated", 32'(e), 2);
      // drain: 0(n1), 1(n2), 2(n1), 3(n1)
      send_arg(2'd0, 2'd0, 8'h10, 2'd0);
      chk(task_valid && task_dest == 2'd0 && task_args[7:0] == 8'h10,
          "R5 drain entry 0", 32'(task_args[7:0]), 32'h10);
      send_arg(2'd1, 2'd1, 8'h21, 2'd1);
      chk(task_valid == 1'b0, "R4 entry 1 still waiting", 32'(task_valid), 0);
      send_arg(2'd1, 2'd0, 8'h20, 2'd2);
      chk(task_valid && task_args[15:0] == 16'h2120 && task_dest == 2'd2,
          "R5 drain entry 1", 32'(task_args[15:0]), 32'h2120);
      send_arg(2'd2, 2'd0, 8'h30, 2'd3);
      chk(task_valid && task_type == 3'd4, "R5 drain entry 2 type", 32'(task_type), 4);
      send_arg(2'd3, 2'd0, 8'h40, 2'd1);
      chk(task_valid && task_type == 3'd3, "R5 drain entry 3 type", 32'(task_type), 3);

      // Sweep: each count, each rotation of arrival order
      for (int n = 1; n <= 3; n++) begin
         for (int r = 0; r < n; r++) begin
            create(3'(n + r), 2'(n), e);
            chk(e == 2'd0, "R2 empty store gives entry 0", 32'(e), 0);
            for (int k = 0; k < n; k++) begin
               int s;
               s = (k + r) % n;
               send_arg(e, 2'(s), 8'(n * 40 + r * 10 + s + 1), 2'((k + r + n) % 4));
               if (k < n - 1) begin
                  chk(task_valid == 1'b0, "R4 sweep partial", 32'(task_valid), 0);
               end else begin
                  chk(task_valid == 1'b1, "R5 sweep complete", 32'(task_valid), 1);
                  chk(task_type == 3'(n + r), "R5 sweep type", 32'(task_type), 32'(n + r));
                  chk(task_dest == 2'((k + r + n) % 4), "R5 sweep dest",
                      32'(task_dest), 32'((k + r + n) % 4));
                  for (int j = 0; j < n; j++)
                     chk(task_args[j*8 +: 8] == 8'(n * 40 + r * 10 + j + 1), "R5 sweep arg",
                         32'(task_args[j*8 +: 8]), 32'(n * 40 + r * 10 + j + 1));
               end
            end
         end
      end

      // R7: value and create in the same cycle
      create(3'd1, 2'd1, e);
      @(negedge clk);
      arg_valid = 1'b1; arg_cont = {e, 2'd0}; arg_data = 8'hAA; arg_src = 2'd1;
      cr_valid = 1'b1; cr_type = 3'd5; cr_nargs = 2'd1;
      #1;
      chk(cr_ready == 1'b0, "R7 create held while value pending", 32'(cr_ready), 0);
      @(negedge clk);
      arg_valid = 1'b0;
      chk(task_valid == 1'b1 && task_args[7:0] == 8'hAA, "R7 value served first",
          32'(task_args[7:0]), 32'hAA);
      chk(rsp_valid == 1'b0, "R7 create not served same cycle", 32'(rsp_valid), 0);
      @(negedge clk);
      cr_valid = 1'b0;
      chk(rsp_valid == 1'b1 && rsp_entry == 2'd0, "R7 create served next", 32'(rsp_entry), 0);
      send_arg(2'd0, 2'd0, 8'h55, 2'd2);
      chk(task_valid && task_type == 3'd5, "R6 entry after priority", 32'(task_type), 5);

      // R8: task backpressure
      create(3'd6, 2'd1, e);
      task_ready = 1'b0;
      send_arg(e, 2'd0, 8'h77, 2'd3);
      chk(task_valid == 1'b1, "R8 task raised", 32'(task_valid), 1);
      repeat (3) begin
         @(negedge clk);
         chk(task_valid && task_args[7:0] == 8'h77 && task_dest == 2'd3 && task_type == 3'd6,
             "R8 task held", 32'(task_args[7:0]), 32'h77);
         chk(arg_ready == 1'b0, "R8 arg_ready low while blocked", 32'(arg_ready), 0);
      end
      task_ready = 1'b1;
      @(negedge clk);
      chk(task_valid == 1'b0, "R8 task consumed", 32'(task_valid), 0);

      // R10: response backpressure
      rsp_ready = 1'b0;
      create(3'd2, 2'd1, e);
      repeat (3) begin
         @(negedge clk);
         chk(rsp_valid && rsp_entry == e, "R10 response held", 32'(rsp_entry), 32'(e));
         chk(cr_ready == 1'b0, "R10 cr_ready low while held", 32'(cr_ready), 0);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R10 response consumed", 32'(rsp_valid), 0);
      send_arg(e, 2'd0, 8'h01, 2'd0);
      chk(task_valid == 1'b1, "R5 drain after R10", 32'(task_valid), 1);

      // R9: stray values ignored
      send_arg(2'd3, 2'd0, 8'hEE, 2'd1);
      chk(task_valid == 1'b0, "R9 value to free entry ignored", 32'(task_valid), 0);
      create(3'd3, 2'd1, e);
      chk(e == 2'd0, "R9 store still empty", 32'(e), 0);
      send_arg(e, 2'd3, 8'hBB, 2'd1);
      chk(task_valid == 1'b0, "R9 out-of-range position ignored", 32'(task_valid), 0);
      send_arg(e, 2'd0, 8'h5A, 2'd2);
      chk(task_valid && task_args[7:0] == 8'h5A && task_dest == 2'd2,
          "R9 entry unaffected by stray value", 32'(task_args[7:0]), 32'h5A);

      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule